// File: doc/BRIEF.md
# Frame Header Recognizer and Receive Gater

This block sits behind a serial demodulator. It watches the received bit stream, one bit per strobe, for a programmable 16-bit frame header. A match then decides what the host sees on three lines: an active-low notification line, the receive clock and the receive data.

Recognition runs only when both the extended-mode enable and the header-recognition enable are set. Otherwise the notification line repeats the carrier/preamble indication supplied from outside, and the clock and data pass straight through. With length counting on, a header match opens a window of exactly the programmed number of 16-bit words. The notification line is low for the whole window, and the clock and data reach the host only inside it. With length counting off, each match gives one bit period of low notification, and the clock and data always pass.

All inputs are synchronous to `clk`. `rx_strobe` is a one-cycle pulse that marks the cycle in which `rx_bit` holds the current bit. Outputs that depend on registered state change on the clock edge that samples a strobe.

Top module: `frame_hdr_gate`

## Requirements
- R1: Unless both `ext_mode_en` and `hdr_rec_en` are 1, `notify_n` equals `carrier_n_in`, `rx_clk_out` equals `rx_clk_in` and `rx_data_out` equals `rx_bit`.
- R2: The header matches when the 16 most recently strobed bits equal `header_val`, with the earliest of them at bit 15 (MSB first), and at least 16 bits have been strobed since the search last restarted. Reset restarts the search.
- R3: With `len_cnt_en`=1, a match opens a window from the edge that samples the last header bit. The window spans the next `frame_words`×16 strobed bits, and a value of 0 counts as 1 word. `notify_n` is 0 exactly while the window is open.
- R4: With `len_cnt_en`=1, `rx_clk_out` is 0 outside the window and equals `rx_clk_in` inside it.
- R5: With `len_cnt_en`=1, `rx_data_out` equals `rx_bit` inside the window. Outside the window it is 1 when `spi_sel`=0 and 0 when `spi_sel`=1.
- R6: While a counted window is open, no header search takes place. A header pattern inside the window's data neither restarts nor extends the window.
- R7: When a counted window closes, the search restarts with an empty history, so a further match needs 16 new bits after the window.
- R8: With `len_cnt_en`=0, a match drives `notify_n` to 0 from the edge that samples the matching bit until the edge that samples the next strobed bit, which is one bit period. If that next bit also completes a match, `notify_n` stays 0.
- R9: With `len_cnt_en`=0 and recognition active, `rx_clk_out` equals `rx_clk_in` and `rx_data_out` equals `rx_bit` at all times.
- R10: After reset with counting active, no window is open: `notify_n`=1, `rx_clk_out`=0 and `rx_data_out` sits at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_strobe | input | 1 | One-cycle pulse marking a valid received bit |
| rx_bit | input | 1 | Received data bit |
| rx_clk_in | input | 1 | Recovered receive clock level |
| carrier_n_in | input | 1 | Active-low carrier/preamble indication from detection logic |
| ext_mode_en | input | 1 | Extended mode enable |
| hdr_rec_en | input | 1 | Header recognition enable |
| len_cnt_en | input | 1 | Frame length counting enable |
| spi_sel | input | 1 | Interface select: 0 gives idle data 1, 1 gives idle data 0 |
| header_val | input | 16 | Header pattern, MSB received first |
| frame_words | input | 8 | Frame length in 16-bit words, 0 treated as 1 |
| notify_n | output | 1 | Active-low notification line |
| rx_clk_out | output | 1 | Gated receive clock to host |
| rx_data_out | output | 1 | Gated receive data to host |

## Verification
A wrong word count or an off-by-one in the bit counter shows within one bit period of the window's end, as a late or early rise of `notify_n` and an idle level on `rx_data_out` at the wrong bit. A history register that is not cleared, or that keeps searching during a window, shows as a premature reopening in the bits that follow. The bench feeds header-shaped data through every window to provoke this. A pulse-mode fault shows at once as a notification lasting zero or two bit periods. The bench sweeps frame lengths 0 to 3, both idle levels, several headers including all-ones and all-zeros, and every enable combination. It compares every cycle of every bit against a model built from the requirements.

// File: rtl/fhg_pkg.sv
package fhg_pkg;

    typedef enum logic [1:0] {
        FHG_OFF   = 2'd0,
        FHG_COUNT = 2'd1,
        FHG_PULSE = 2'd2
    } fhg_mode_e;

    function automatic fhg_mode_e fhg_decode(input logic ext_en,
                                             input logic rec_en,
                                             input logic cnt_en);
        if (!(ext_en && rec_en))
            return FHG_OFF;
        else if (cnt_en)
            return FHG_COUNT;
        else
            return FHG_PULSE;
    endfunction

endpackage

// File: rtl/fhg_hist.sv
module fhg_hist #(
    parameter int HDR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             bit_in,
    input  logic             search_en,
    input  logic             restart,
    input  logic [HDR_W-1:0] header,
    output logic             match
);
    localparam int FILL_W = $clog2(HDR_W + 1);

    typedef struct packed {
        logic [HDR_W-1:0]  hist;
        logic [FILL_W-1:0] fill;
    } hist_st_t;

    hist_st_t         s_d, s_q;
    logic [HDR_W-1:0] shifted;
    logic             full_next;

    always_comb begin
        s_d       = s_q;
        shifted   = {s_q.hist[HDR_W-2:0], bit_in};
        full_next = (s_q.fill >= FILL_W'(HDR_W - 1));
        match     = 1'b0;
        if (restart) begin
            s_d.hist = '0;
            s_d.fill = '0;
        end else if (strobe && search_en) begin
            s_d.hist = shifted;
            if (s_q.fill != FILL_W'(HDR_W))
                s_d.fill = s_q.fill + 1'b1;
            match = full_next && (shifted == header);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fill <= FILL_W'(HDR_W));

    assert_match_hist_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (s_q.hist == $past(header)));

endmodule

// File: rtl/fhg_window.sv
module fhg_window #(
    parameter int LEN_W     = 8,
    parameter int WORD_BITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             strobe,
    input  logic             open_req,
    input  logic [LEN_W-1:0] frame_words,
    output logic             win,
    output logic             closing
);
    localparam int CNT_W = LEN_W + $clog2(WORD_BITS) + 1;

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] left;
    } win_st_t;

    win_st_t          s_d, s_q;
    logic [LEN_W-1:0] words_eff;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        s_d       = s_q;
        words_eff = (frame_words == '0) ? LEN_W'(1) : frame_words;
        load_val  = CNT_W'(words_eff) * CNT_W'(WORD_BITS);
        closing   = s_q.open && strobe && (s_q.left == CNT_W'(1));
        if (!en) begin
            s_d = '0;
        end else if (s_q.open) begin
            if (strobe) begin
                s_d.left = s_q.left - 1'b1;
                if (closing) s_d.open = 1'b0;
            end
        end else if (open_req) begin
            s_d.open = 1'b1;
            s_d.left = load_val;
        end
    end

    assign win = s_q.open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_left_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.open |-> (s_q.left != '0));

    assert_close_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.open && $past(s_q.open) && $past(en)) |->
            ($past(strobe) && ($past(s_q.left) == CNT_W'(1))));

    assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.open && !strobe && en) |=> s_q.open);

endmodule

// File: rtl/fhg_pulse.sv
module fhg_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic strobe,
    input  logic hit,
    output logic pulse
);
    typedef struct packed {
        logic pulse;
    } pulse_st_t;

    pulse_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en)         s_d.pulse = 1'b0;
        else if (strobe) s_d.pulse = hit;
    end

    assign pulse = s_q.pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_pulse_starts_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pulse) |-> $past(strobe));

    assert_pulse_ends_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_q.pulse) && $past(en)) |-> $past(strobe));

endmodule

// File: rtl/fhg_outmux.sv
module fhg_outmux
    import fhg_pkg::*;
(
    input  fhg_mode_e mode,
    input  logic      win,
    input  logic      pulse,
    input  logic      carrier_n_in,
    input  logic      rx_clk_in,
    input  logic      rx_bit,
    input  logic      spi_sel,
    output logic      notify_n,
    output logic      rx_clk_out,
    output logic      rx_data_out
);
    always_comb begin
        case (mode)
            FHG_COUNT: begin
                notify_n    = !win;
                rx_clk_out  = win && rx_clk_in;
                rx_data_out = win ? rx_bit : !spi_sel;
            end
            FHG_PULSE: begin
                notify_n    = !pulse;
                rx_clk_out  = rx_clk_in;
                rx_data_out = rx_bit;
            end
            default: begin
                notify_n    = carrier_n_in;
                rx_clk_out  = rx_clk_in;
                rx_data_out = rx_bit;
            end
        endcase
    end

endmodule

// File: rtl/frame_hdr_gate.sv
module frame_hdr_gate
    import fhg_pkg::*;
#(
    parameter int HDR_W     = 16,
    parameter int LEN_W     = 8,
    parameter int WORD_BITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_strobe,
    input  logic             rx_bit,
    input  logic             rx_clk_in,
    input  logic             carrier_n_in,
    input  logic             ext_mode_en,
    input  logic             hdr_rec_en,
    input  logic             len_cnt_en,
    input  logic             spi_sel,
    input  logic [HDR_W-1:0] header_val,
    input  logic [LEN_W-1:0] frame_words,
    output logic             notify_n,
    output logic             rx_clk_out,
    output logic             rx_data_out
);
    fhg_mode_e mode;
    logic      active, count_mode, pulse_mode;
    logic      win, closing, match, pulse;
    logic      search_en, restart;

    always_comb begin
        mode       = fhg_decode(ext_mode_en, hdr_rec_en, len_cnt_en);
        active     = (mode != FHG_OFF);
        count_mode = (mode == FHG_COUNT);
        pulse_mode = (mode == FHG_PULSE);
        search_en  = active && !(count_mode && win);
        restart    = !active || closing;
    end

    fhg_hist #(.HDR_W(HDR_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (rx_strobe),
        .bit_in    (rx_bit),
        .search_en (search_en),
        .restart   (restart),
        .header    (header_val),
        .match     (match)
    );

    fhg_window #(.LEN_W(LEN_W), .WORD_BITS(WORD_BITS)) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (count_mode),
        .strobe      (rx_strobe),
        .open_req    (match && count_mode),
        .frame_words (frame_words),
        .win         (win),
        .closing     (closing)
    );

    fhg_pulse u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (pulse_mode),
        .strobe (rx_strobe),
        .hit    (match && pulse_mode),
        .pulse  (pulse)
    );

    fhg_outmux u_outmux (
        .mode         (mode),
        .win          (win),
        .pulse        (pulse),
        .carrier_n_in (carrier_n_in),
        .rx_clk_in    (rx_clk_in),
        .rx_bit       (rx_bit),
        .spi_sel      (spi_sel),
        .notify_n     (notify_n),
        .rx_clk_out   (rx_clk_out),
        .rx_data_out  (rx_data_out)
    );

    assert_clk_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_mode && !win) |-> !rx_clk_out);

    assert_data_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_mode && !win) |-> (rx_data_out == !spi_sel));

    assert_no_search_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_mode && win) |-> !match);

endmodule

// File: tb/tb_frame_hdr_gate.sv
module tb_frame_hdr_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_strobe = 1'b0, rx_bit = 1'b0, rx_clk_in = 1'b0;
    logic        carrier_n_in = 1'b1;
    logic        ext_mode_en = 1'b0, hdr_rec_en = 1'b0, len_cnt_en = 1'b0, spi_sel = 1'b0;
    logic [15:0] header_val = '0;
    logic [7:0]  frame_words = '0;
    logic        notify_n, rx_clk_out, rx_data_out;

    int n_chk = 0, n_bad = 0;

    logic [15:0] bm_hist;
    int          bm_fill, bm_left;
    bit          bm_pulse;

    always #10 clk = ~clk;

    frame_hdr_gate dut (
        .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_bit(rx_bit),
        .rx_clk_in(rx_clk_in), .carrier_n_in(carrier_n_in),
        .ext_mode_en(ext_mode_en), .hdr_rec_en(hdr_rec_en), .len_cnt_en(len_cnt_en),
        .spi_sel(spi_sel), .header_val(header_val), .frame_words(frame_words),
        .notify_n(notify_n), .rx_clk_out(rx_clk_out), .rx_data_out(rx_data_out)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx_strobe = 1'b0; rx_clk_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bm_hist = '0; bm_fill = 0; bm_left = 0; bm_pulse = 1'b0;
    endtask

    task automatic send_bit(input logic b, input string tag, input logic car);
        bit  active = ext_mode_en && hdr_rec_en;
        bit  cnt    = active && len_cnt_en;
        bit  inwin  = (bm_left > 0);
        bit  hit;
        int  wl;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            rx_bit = b; rx_clk_in = (c < 2); rx_strobe = (c == 3); carrier_n_in = car;
            #2;
            if (!active) begin
                chk("R1", "notify_n", notify_n, car);
                chk("R1", "rx_clk_out", rx_clk_out, rx_clk_in);
                chk("R1", "rx_data_out", rx_data_out, b);
            end else if (cnt) begin
                chk(tag, "notify_n", notify_n, !inwin);
                chk("R4", "rx_clk_out", rx_clk_out, inwin && (c < 2));
                chk("R5", "rx_data_out", rx_data_out, inwin ? b : !spi_sel);
            end else begin
                chk(tag, "notify_n", notify_n, !bm_pulse);
                chk("R9", "rx_clk_out", rx_clk_out, rx_clk_in);
                chk("R9", "rx_data_out", rx_data_out, b);
            end
        end
        if (!active) begin
            bm_hist = '0; bm_fill = 0;
        end else if (cnt && inwin) begin
            bm_left--;
            if (bm_left == 0) begin bm_fill = 0; bm_hist = '0; end
        end else begin
            bm_hist = {bm_hist[14:0], b};
            if (bm_fill < 16) bm_fill++;
            hit = (bm_fill >= 16) && (bm_hist == header_val);
            if (cnt) begin
                if (hit) begin
                    wl = (frame_words == 0) ? 1 : int'(frame_words);
                    bm_left = wl * 16;
                    bm_fill = 0; bm_hist = '0;
                end
            end else begin
                bm_pulse = hit;
            end
        end
    endtask

    task automatic send_word(input logic [15:0] w, input string tag);
        for (int i = 15; i >= 0; i--) send_bit(w[i], tag, 1'b1);
    endtask

    task automatic count_case(input logic [15:0] h, input int words, input logic spi);
        ext_mode_en = 1; hdr_rec_en = 1; len_cnt_en = 1; spi_sel = spi;
        header_val = h; frame_words = 8'(words);
        do_reset();
        @(negedge clk); rx_clk_in = 1'b1; #2;
        chk("R10", "notify_n after reset", notify_n, 1'b1);
        chk("R10", "rx_clk_out after reset", rx_clk_out, 1'b0);
        chk("R10", "rx_data_out after reset", rx_data_out, !spi);
        send_word(h, "R2");
        for (int k = 0; k < ((words == 0) ? 1 : words); k++) send_word(h, "R6");
        send_word(h, "R7");
        for (int k = 0; k < ((words == 0) ? 1 : words); k++) send_word(~h, "R3");
        for (int k = 0; k < 8; k++) send_bit(k[0], "R7", 1'b1);
    endtask

    task automatic pulse_case(input logic [15:0] h);
        ext_mode_en = 1; hdr_rec_en = 1; len_cnt_en = 0; spi_sel = 0;
        header_val = h; frame_words = 8'd2;
        do_reset();
        send_word(h, "R2");
        send_word(h, "R8");
        for (int k = 0; k < 20; k++) send_bit(k[0], "R8", 1'b1);
        for (int k = 0; k < 20; k++) send_bit(h[0], "R8", 1'b1);
    endtask

    task automatic off_case(input logic e, input logic r, input logic l, input logic [15:0] h);
        ext_mode_en = e; hdr_rec_en = r; len_cnt_en = l; spi_sel = 1;
        header_val = h; frame_words = 8'd1;
        do_reset();
        for (int i = 15; i >= 0; i--) send_bit(h[i], "R1", h[i] ^ i[0]);
        for (int k = 0; k < 24; k++) send_bit(k[1], "R1", k[2]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] hdrs [3];
        logic [15:0] phdrs [4];
        hdrs[0] = 16'hA5C3; hdrs[1] = 16'h8001; hdrs[2] = 16'hFFFF;
        phdrs[0] = 16'hA5C3; phdrs[1] = 16'hFFFF; phdrs[2] = 16'h0000; phdrs[3] = 16'h6DB6;
        for (int hi = 0; hi < 3; hi++)
            for (int w = 0; w < 4; w++)
                for (int s = 0; s < 2; s++)
                    count_case(hdrs[hi], w, s[0]);
        for (int hi = 0; hi < 4; hi++) pulse_case(phdrs[hi]);
        for (int m = 0; m < 3; m++)
            for (int l = 0; l < 2; l++)
                off_case(m[1], m[0], l[0], 16'h5A3C);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule